// File: doc/BRIEF.md
# Serial Receive Bit-Period Tracker

This block watches the sampled receive line of a serial port and measures how long a bit really lasts. Software seeds it with a nominal cycles-per-bit value. The value has 4 fractional bits and must have an integer part of at least 17. Once enabled, the tracker opens a measurement window on the first falling edge of the line. It keeps counting clock cycles across consecutive characters until enough bit times have gone by. It then divides the cycle total by the bit total and hands the average back as the new cycles-per-bit value for the receiver. This removes both the remote sender's rate error and the local clock's drift.

Bit times are judged against the current estimate with round-half-up rounding, and the window can only close on a line transition. The quotient comes from a sequential restoring divider. It carries 4 fractional bits and saturates to the 20-bit field. Monitoring and fractional rate adjustment cannot be used together, so the fractional adjust handed to the receiver is forced to zero while the monitor is enabled.

Top module: `baud_rate_monitor`

## Requirements
- R1: While `monEn` is low, `cpbOut` takes the value of `initCpb` one clock later, `monRdy` is low, and `rxFracAdj` equals `fracAdjIn`.
- R2: While `monEn` is high, `rxFracAdj` is zero.
- R3: With the monitor enabled and idle, the first 1-to-0 transition of `rxIn` opens the window, provided the integer part of the estimate (`cpbOut[19:4]`) is at least 17. M is the number of clocks between the sampled opening edge and the sampled closing edge, and `totalCycles` reports M once the window has closed.
- R4: C is the integer part of the estimate and Neff is `bitThresh` clamped to the range 1..127, so 0 gives 1 and values above 127 give 127. At each sampled transition the elapsed bit count is floor((M + floor(C/2)) / C). The window closes at the first transition at which this count is at least Neff.
- R5: `totalBits` reports the bit count at closing, and this count is never zero.
- R6: After closing, `cpbOut` becomes floor(16*M / bits), a value with 4 fractional bits. If that result does not fit in 20 bits, `cpbOut` becomes 20'hFFFFF.
- R7: `monRdy` is first seen high exactly 34 cycles after the last clock before the closing edge is sampled (the divider takes 32 steps). `monRdy` drops one clock after `monEn` goes low, and `cpbOut` then returns to `initCpb`.
- R8: `monIrq` is set in the same clock that `monRdy` rises. It stays set when `monEn` goes low and is cleared only by `irqClr`. A new completion takes priority over a clear in the same clock.
- R9: `cpbInvalid` is high when `monEn` is high and the integer part of the estimate is below 17. In that state no measurement starts, and `cpbOut`, `totalCycles` and `monRdy` do not change.
- R10: After a completion, further activity on `rxIn` changes neither `cpbOut`, `totalCycles`, `totalBits` nor `monRdy` until `monEn` is lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Receive line, already synchronized to `clk` |
| monEn | input | 1 | Monitor enable |
| initCpb | input | 20 | Initial cycles-per-bit, 16 integer and 4 fractional bits |
| bitThresh | input | 8 | Number of bit times to measure (clamped to 1..127) |
| fracAdjIn | input | 11 | Fractional rate adjust requested by software |
| irqClr | input | 1 | Clears the done interrupt |
| cpbOut | output | 20 | Cycles-per-bit value handed to the receiver |
| monRdy | output | 1 | Measurement and division finished |
| totalCycles | output | 28 | Clock cycles spanned by the last window |
| totalBits | output | 8 | Bit times counted in the last window |
| monIrq | output | 1 | Sticky done interrupt |
| cpbInvalid | output | 1 | Estimate below 17 cycles per bit while enabled |
| rxFracAdj | output | 11 | Fractional adjust passed to the receiver |

## Verification
The hardest case to reach from the ports is quotient saturation. It needs a window whose cycles-per-bit average does not fit the 20-bit field. That only happens with a very large estimate, a single counted bit, and a long low pulse. The bench therefore seeds an integer part of 65535, sets a threshold of one bit, and holds the line low for 70000 cycles. For that span the rounded bit count is still 1 and the scaled quotient overflows. The main sweeps vary the estimate, the true bit period and the threshold over a fixed character stream, and recompute each closing edge in the bench.

// File: rtl/baud_mon_pkg.sv
package baud_mon_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ARM,
    ST_MEAS,
    ST_DIV,
    ST_HOLD
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInit;   // copy software seed into the estimate
    logic startWin;   // falling edge accepted, open the window
    logic measuring;  // window open, advance counters
    logic closeWin;   // capture totals and launch the divider
    logic commit;     // divider finished, write back the quotient
  } monStrobe_t;

endpackage

// File: rtl/baud_mon_div.sv
module baud_mon_div #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             done
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quoReg;
  logic [DVS_W-1:0] remReg;
  logic [DVS_W-1:0] dvsReg;
  logic [CNT_W-1:0] stepCnt;
  logic             busy;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {remReg, quoReg[DVD_W-1]};
    diff  = trial - {1'b0, dvsReg};
    fits  = (trial >= {1'b0, dvsReg});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg  <= '0;
      remReg  <= '0;
      dvsReg  <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quoReg  <= dividend;
        remReg  <= '0;
        dvsReg  <= divisor;
        stepCnt <= CNT_W'(DVD_W);
        busy    <= 1'b1;
      end else if (busy) begin
        remReg  <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        quoReg  <= {quoReg[DVD_W-2:0], fits};
        stepCnt <= stepCnt - 1'b1;
        if (stepCnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoReg;

endmodule

// File: rtl/baud_mon_dpath.sv
module baud_mon_dpath
  import baud_mon_pkg::*;
#(
  parameter int CPB_W    = 20,
  parameter int FRAC_W   = 4,
  parameter int CYC_W    = 28,
  parameter int BIT_W    = 8,
  parameter int MAX_BITS = 127,
  parameter int MIN_CPB  = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic [CPB_W-1:0] initCpb,
  input  logic [BIT_W-1:0] bitThresh,
  input  monStrobe_t       strb,
  output logic [CPB_W-1:0] cpbOut,
  output logic [CYC_W-1:0] totalCycles,
  output logic [BIT_W-1:0] totalBits,
  output logic             fallEdge,
  output logic             anyEdge,
  output logic             enoughBits,
  output logic             cpbLow,
  output logic             divDone
);

  localparam int INT_W = CPB_W - FRAC_W;
  localparam int DVD_W = CYC_W + FRAC_W;
  localparam logic [BIT_W-1:0] MAXB = BIT_W'(MAX_BITS);

  logic             rxPrev;
  logic [CPB_W-1:0] cpbReg;
  logic [CPB_W-1:0] cpbNext;
  logic [INT_W-1:0] cpbInt;
  logic [INT_W-1:0] halfBit;
  logic [INT_W-1:0] phase;
  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] cycCap;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] bitCap;
  logic [BIT_W-1:0] nEff;
  logic [DVD_W-1:0] quotient;

  // line edge detection on the synchronized input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxIn;
  end

  assign fallEdge = rxPrev & ~rxIn;
  assign anyEdge  = rxPrev ^ rxIn;

  assign cpbInt  = cpbReg[CPB_W-1:FRAC_W];
  assign halfBit = cpbInt >> 1;
  assign cpbLow  = (cpbInt < INT_W'(MIN_CPB));

  // effective bit threshold, clamped to 1..MAX_BITS
  always_comb begin
    nEff = bitThresh;
    if (bitThresh == '0)       nEff = BIT_W'(1);
    else if (bitThresh > MAXB) nEff = MAXB;
  end

  assign enoughBits = (bitCnt >= nEff);

  // window counters: cycles, phase within a bit, rounded bit count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (strb.startWin) begin
      cycCnt <= CYC_W'(1);
      phase  <= halfBit + 1'b1;
      bitCnt <= '0;
    end else if (strb.measuring) begin
      if (cycCnt != '1) cycCnt <= cycCnt + 1'b1;
      if (phase == cpbInt - 1'b1) begin
        phase <= '0;
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCap <= '0;
      bitCap <= '0;
    end else if (strb.closeWin) begin
      cycCap <= cycCnt;
      bitCap <= bitCnt;
    end
  end

  baud_mon_div #(
    .DVD_W(DVD_W),
    .DVS_W(BIT_W)
  ) div_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (strb.closeWin),
    .dividend({cycCnt, {FRAC_W{1'b0}}}),
    .divisor (bitCnt),
    .quotient(quotient),
    .done    (divDone)
  );

  // narrow the quotient into the estimate field, saturating on overflow
  generate
    if (DVD_W > CPB_W) begin : g_sat
      assign cpbNext = (|quotient[DVD_W-1:CPB_W]) ? '1 : quotient[CPB_W-1:0];
    end else begin : g_fit
      assign cpbNext = CPB_W'(quotient);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cpbReg <= '0;
    else if (strb.loadInit) cpbReg <= initCpb;
    else if (strb.commit)   cpbReg <= cpbNext;
  end

  assign cpbOut      = cpbReg;
  assign totalCycles = cycCap;
  assign totalBits   = bitCap;

endmodule

// File: rtl/baud_mon_ctrl.sv
module baud_mon_ctrl
  import baud_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       monEn,
  input  logic       irqClr,
  input  logic       fallEdge,
  input  logic       anyEdge,
  input  logic       enoughBits,
  input  logic       cpbLow,
  input  logic       divDone,
  output monStrobe_t strb,
  output logic       monRdy,
  output logic       monIrq
);

  monState_t state;
  monState_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (!monEn) begin
      strb.loadInit = 1'b1;
      stateNext     = ST_OFF;
    end else begin
      case (state)
        ST_OFF: stateNext = ST_ARM;
        ST_ARM: begin
          if (fallEdge && !cpbLow) begin
            strb.startWin = 1'b1;
            stateNext     = ST_MEAS;
          end
        end
        ST_MEAS: begin
          strb.measuring = 1'b1;
          if (anyEdge && enoughBits) begin
            strb.closeWin = 1'b1;
            stateNext     = ST_DIV;
          end
        end
        ST_DIV: begin
          if (divDone) begin
            strb.commit = 1'b1;
            stateNext   = ST_HOLD;
          end
        end
        default: stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      monRdy <= 1'b0;
      monIrq <= 1'b0;
    end else begin
      state <= stateNext;
      if (!monEn)           monRdy <= 1'b0;
      else if (strb.commit) monRdy <= 1'b1;
      if (strb.commit)      monIrq <= 1'b1;
      else if (irqClr)      monIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_rate_monitor.sv
module baud_rate_monitor
  import baud_mon_pkg::*;
#(
  parameter int CPB_W    = 20,
  parameter int FRAC_W   = 4,
  parameter int CYC_W    = 28,
  parameter int BIT_W    = 8,
  parameter int ADJ_W    = 11,
  parameter int MAX_BITS = 127,
  parameter int MIN_CPB  = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             monEn,
  input  logic [CPB_W-1:0] initCpb,
  input  logic [BIT_W-1:0] bitThresh,
  input  logic [ADJ_W-1:0] fracAdjIn,
  input  logic             irqClr,
  output logic [CPB_W-1:0] cpbOut,
  output logic             monRdy,
  output logic [CYC_W-1:0] totalCycles,
  output logic [BIT_W-1:0] totalBits,
  output logic             monIrq,
  output logic             cpbInvalid,
  output logic [ADJ_W-1:0] rxFracAdj
);

  monStrobe_t strb;
  logic fallEdge;
  logic anyEdge;
  logic enoughBits;
  logic cpbLow;
  logic divDone;

  baud_mon_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .monEn     (monEn),
    .irqClr    (irqClr),
    .fallEdge  (fallEdge),
    .anyEdge   (anyEdge),
    .enoughBits(enoughBits),
    .cpbLow    (cpbLow),
    .divDone   (divDone),
    .strb      (strb),
    .monRdy    (monRdy),
    .monIrq    (monIrq)
  );

  baud_mon_dpath #(
    .CPB_W   (CPB_W),
    .FRAC_W  (FRAC_W),
    .CYC_W   (CYC_W),
    .BIT_W   (BIT_W),
    .MAX_BITS(MAX_BITS),
    .MIN_CPB (MIN_CPB)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxIn       (rxIn),
    .initCpb    (initCpb),
    .bitThresh  (bitThresh),
    .strb       (strb),
    .cpbOut     (cpbOut),
    .totalCycles(totalCycles),
    .totalBits  (totalBits),
    .fallEdge   (fallEdge),
    .anyEdge    (anyEdge),
    .enoughBits (enoughBits),
    .cpbLow     (cpbLow),
    .divDone    (divDone)
  );

  assign cpbInvalid = monEn & cpbLow;
  // the fractional adjust and the monitor never work together
  assign rxFracAdj  = monEn ? '0 : fracAdjIn;

endmodule

// File: rtl/baud_rate_monitor_chk.sv
module baud_rate_monitor_chk #(
  parameter int CPB_W = 20,
  parameter int CYC_W = 28,
  parameter int BIT_W = 8,
  parameter int ADJ_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             monEn,
  input logic [CPB_W-1:0] initCpb,
  input logic             irqClr,
  input logic [CPB_W-1:0] cpbOut,
  input logic             monRdy,
  input logic [CYC_W-1:0] totalCycles,
  input logic [BIT_W-1:0] totalBits,
  input logic             monIrq,
  input logic             cpbInvalid,
  input logic [ADJ_W-1:0] rxFracAdj
);

  assert_seed_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |=> (cpbOut == $past(initCpb)));

  assert_adj_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    monEn |-> (rxFracAdj == '0));

  assert_bits_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(monRdy) |-> (totalBits != '0));

  assert_rdy_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |=> !monRdy);

  assert_irq_with_rdy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(monRdy) |-> monIrq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (monIrq && !irqClr) |=> monIrq);

  assert_invalid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpbInvalid && !monRdy) |=> !monRdy);

  assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (monRdy && monEn) |=> ($stable(cpbOut) && $stable(totalCycles) && $stable(totalBits)));

endmodule

bind baud_rate_monitor baud_rate_monitor_chk #(
  .CPB_W(CPB_W),
  .CYC_W(CYC_W),
  .BIT_W(BIT_W),
  .ADJ_W(ADJ_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .monEn      (monEn),
  .initCpb    (initCpb),
  .irqClr     (irqClr),
  .cpbOut     (cpbOut),
  .monRdy     (monRdy),
  .totalCycles(totalCycles),
  .totalBits  (totalBits),
  .monIrq     (monIrq),
  .cpbInvalid (cpbInvalid),
  .rxFracAdj  (rxFracAdj)
);

// File: tb/baud_rate_monitor_tb_top.sv
`timescale 1ns/1ps
module baud_rate_monitor_tb_top;

  localparam int SLEN = 160;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic        monEn = 1'b0;
  logic [19:0] initCpb = 20'd0;
  logic [7:0]  bitThresh = 8'd1;
  logic [10:0] fracAdjIn = 11'd0;
  logic        irqClr = 1'b0;
  logic [19:0] cpbOut;
  logic        monRdy;
  logic [27:0] totalCycles;
  logic [7:0]  totalBits;
  logic        monIrq;
  logic        cpbInvalid;
  logic [10:0] rxFracAdj;

  int checks = 0;
  int errors = 0;
  int cycN = 0;
  int closeCyc = 0;
  int rdyCyc = 0;
  logic rdySeen = 1'b0;
  logic rdyWatch = 1'b0;
  logic streamBits [0:SLEN-1];

  always #10 clk = ~clk;

  always @(posedge clk) cycN <= cycN + 1;

  always @(negedge clk) begin
    if (rdyWatch && !rdySeen && monRdy) begin
      rdySeen = 1'b1;
      rdyCyc  = cycN;
    end
  end

  baud_rate_monitor dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .monEn(monEn), .initCpb(initCpb),
    .bitThresh(bitThresh), .fracAdjIn(fracAdjIn), .irqClr(irqClr),
    .cpbOut(cpbOut), .monRdy(monRdy), .totalCycles(totalCycles),
    .totalBits(totalBits), .monIrq(monIrq), .cpbInvalid(cpbInvalid),
    .rxFracAdj(rxFracAdj)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic buildStream();
    logic [7:0] bytesArr [0:3];
    int k;
    bytesArr[0] = 8'h4B; bytesArr[1] = 8'h00; bytesArr[2] = 8'hF0; bytesArr[3] = 8'h96;
    k = 0;
    streamBits[k++] = 1'b1;
    streamBits[k++] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      streamBits[k++] = 1'b0;
      for (int b = 0; b < 8; b++) streamBits[k++] = bytesArr[c][b];
      streamBits[k++] = 1'b1;
    end
    while (k < SLEN) begin
      streamBits[k] = k[0] ? 1'b1 : 1'b0;
      k++;
    end
  endtask

  // reference model of the window from the requirements (R3, R4, R6)
  task automatic calcExp(input int c, input int p, input int thr,
                         output int idx, output int m, output int bits, output int cpb);
    int n, h, k0, b;
    n = (thr == 0) ? 1 : ((thr > 127) ? 127 : thr);
    h = c / 2;
    idx = -1; m = 0; bits = 0; cpb = 0; k0 = -1;
    for (int i = 1; i < SLEN; i++) begin
      if (k0 < 0) begin
        if (streamBits[i-1] && !streamBits[i]) k0 = i;
      end else if (idx < 0 && streamBits[i] != streamBits[i-1]) begin
        b = ((i - k0) * p + h) / c;
        if (b > 255) b = 255;
        if (b >= n) begin
          idx = i; m = (i - k0) * p; bits = b;
        end
      end
    end
    if (idx >= 0) begin
      cpb = (m * 16) / bits;
      if (cpb > 20'hFFFFF) cpb = 20'hFFFFF;
    end
  endtask

  task automatic rearm(input logic [19:0] seed, input logic [7:0] thr);
    @(negedge clk);
    monEn = 1'b0; initCpb = seed; bitThresh = thr; irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0; monEn = 1'b1;
    repeat (2) @(negedge clk);
    rdySeen = 1'b0; rdyWatch = 1'b1;
  endtask

  task automatic waitRdy(input string req);
    int n = 0;
    while (!rdySeen && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, rdySeen}, 32'd1);
  endtask

  task automatic runOne(input int c, input int p, input int thr);
    int idx, m, bits, cpb;
    calcExp(c, p, thr, idx, m, bits, cpb);
    check("R4 window closes inside stream", {31'd0, (idx >= 0)}, 32'd1);
    if (idx >= 0) begin
      rearm(20'(c << 4), 8'(thr));
      for (int i = 0; i <= idx; i++) begin
        @(negedge clk);
        rxIn = streamBits[i];
        if (i == idx) closeCyc = cycN;
        repeat (p - 1) @(negedge clk);
      end
      @(negedge clk);
      rxIn = 1'b1;
      waitRdy("R7 ready rises");
      check("R7 ready latency", 32'(rdyCyc - closeCyc), 32'd34);
      check("R3 total cycles", {4'd0, totalCycles}, 32'(m));
      check("R5 total bits", {24'd0, totalBits}, 32'(bits));
      check("R6 averaged estimate", {12'd0, cpbOut}, 32'(cpb));
      check("R8 irq set at completion", {31'd0, monIrq}, 32'd1);
    end
  endtask

  initial begin
    logic [19:0] heldCpb;
    logic [27:0] heldCyc;
    logic [7:0]  heldBits;
    int pOff [0:2];
    int thrs [0:2];
    pOff[0] = -2; pOff[1] = 0; pOff[2] = 3;
    thrs[0] = 1;  thrs[1] = 5; thrs[2] = 16;
    buildStream();

    repeat (3) @(negedge clk);
    check("R7 reset ready low", {31'd0, monRdy}, 32'd0);
    check("R8 reset irq low", {31'd0, monIrq}, 32'd0);
    check("R3 reset cycles zero", {4'd0, totalCycles}, 32'd0);
    check("R5 reset bits zero", {24'd0, totalBits}, 32'd0);
    rstN = 1'b1;

    // R1 / R2: disabled follow, adjust pass and mask
    @(negedge clk);
    initCpb = 20'h00150; fracAdjIn = 11'h5A3;
    @(negedge clk);
    check("R1 estimate follows seed", {12'd0, cpbOut}, 32'h00150);
    check("R1 adjust passes through", {21'd0, rxFracAdj}, 32'h5A3);
    check("R1 ready low while disabled", {31'd0, monRdy}, 32'd0);
    monEn = 1'b1;
    @(negedge clk);
    check("R2 adjust masked when enabled", {21'd0, rxFracAdj}, 32'd0);
    monEn = 1'b0;

    // R3..R8 sweep: estimate, true period, threshold
    for (int ci = 0; ci < 2; ci++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int ti = 0; ti < 3; ti++) begin
          int c = (ci == 0) ? 17 : 23;
          runOne(c, c + pOff[pi], thrs[ti]);
        end
      end
    end

    // R4 clamp corners
    runOne(20, 19, 0);
    runOne(17, 17, 200);

    // R10: more line activity after completion changes nothing
    heldCpb = cpbOut; heldCyc = totalCycles; heldBits = totalBits;
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      rxIn = streamBits[i];
      repeat (15) @(negedge clk);
    end
    check("R10 estimate held", {12'd0, cpbOut}, {12'd0, heldCpb});
    check("R10 cycles held", {4'd0, totalCycles}, {4'd0, heldCyc});
    check("R10 bits held", {24'd0, totalBits}, {24'd0, heldBits});
    check("R10 ready held", {31'd0, monRdy}, 32'd1);

    // R7 / R8: disable drops ready, reload seed, irq sticky until clear
    @(negedge clk);
    initCpb = 20'h00200; monEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7 ready drops on disable", {31'd0, monRdy}, 32'd0);
    check("R7 seed reloaded", {12'd0, cpbOut}, 32'h00200);
    check("R8 irq sticky across disable", {31'd0, monIrq}, 32'd1);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    @(negedge clk);
    check("R8 irq cleared", {31'd0, monIrq}, 32'd0);

    // R9: seed below 17 cycles per bit
    heldCyc = totalCycles;
    rearm(20'h00100, 8'd1);
    check("R9 invalid flagged", {31'd0, cpbInvalid}, 32'd1);
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      rxIn = streamBits[i];
      repeat (15) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check("R9 no ready", {31'd0, monRdy}, 32'd0);
    check("R9 estimate unchanged", {12'd0, cpbOut}, 32'h00100);
    check("R9 cycles unchanged", {4'd0, totalCycles}, {4'd0, heldCyc});

    // R6 saturation: huge estimate, single bit, long low pulse
    rearm(20'hFFFF0, 8'd1);
    check("R9 large seed valid", {31'd0, cpbInvalid}, 32'd0);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (70000) @(negedge clk);
    rxIn = 1'b1;
    closeCyc = cycN;
    waitRdy("R6 ready after long pulse");
    check("R7 ready latency long pulse", 32'(rdyCyc - closeCyc), 32'd34);
    check("R3 cycles long pulse", {4'd0, totalCycles}, 32'd70000);
    check("R5 bits long pulse", {24'd0, totalBits}, 32'd1);
    check("R6 saturated estimate", {12'd0, cpbOut}, 32'hFFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual cycles %0d expected below %0d", cycN, 195000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule